// File: doc/BRIEF.md
# Section Parity Code Generator and B1 Inserter

This block produces the section-level bit-interleaved parity code for a byte-wide transmit frame stream and writes it into the B1 overhead byte. It watches two points in the transmit pipeline. The first is the byte stream before scrambling, which passes through the block and has its B1 byte replaced. The second is the scrambled byte stream further down the pipeline, which the block only reads to accumulate parity. Each stream marks the first byte of a frame with its own start-of-frame flag.

Parity is even and bit-interleaved. Bit k of the code is the XOR of bit k of every scrambled byte in one frame, including the framing bytes. The code finished at the end of frame N goes into B1 of frame N+1. In the first frame after reset no finished code exists yet, so zero is written. A diagnostic input, while high, inverts the inserted byte in every frame, which injects a parity error continuously. The frame geometry and the B1 position are parameters. The defaults are 9 rows of 270 columns, with B1 at zero-based row 1, column 0, which is byte index 270 counted from the start-of-frame byte.

Top module: `bip8_section_gen`

## Requirements
- R1: During and right after synchronous reset, `tx_out_valid`, `tx_out_sof` and `tx_out_data` are 0.
- R2: Every valid pre-scrambler byte that is not at the B1 index appears unchanged on `tx_out_data` one clock later.
- R3: The valid pre-scrambler byte at index B1_ROW*FRAME_COLS+B1_COL is replaced on the output. Index 0 is the byte flagged by `tx_in_sof`, and only valid bytes are counted.
- R4: The code equals the XOR of the FRAME_COLS*FRAME_ROWS valid scrambled bytes that start at the byte flagged by `scr_sof`. The framing bytes are included.
- R5: The code of scrambled frame N is the value written into B1 of frame N+1. A frame that is cut short by a new `scr_sof` produces no code, and the previous code stays in force.
- R6: Until the first scrambled frame has completed after reset, B1 is written as 8'h00.
- R7: While `err_inject` is high at the B1 byte, the written byte is the bitwise inverse of the value R5/R6 would give. This applies in every frame, including the first.
- R8: A start-of-frame flag restarts the byte index of its own stream at 0, whatever the current count.
- R9: `tx_out_valid` is `tx_in_valid` delayed by one clock. `tx_out_sof` is `tx_in_valid & tx_in_sof` delayed by one clock.
- R10: Cycles with a low valid input have no effect on that stream's byte index or parity. In those cycles the data and start-of-frame inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_in_valid | input | 1 | Pre-scrambler byte valid |
| tx_in_sof | input | 1 | Marks the first byte of a pre-scrambler frame |
| tx_in_data | input | 8 | Pre-scrambler byte |
| scr_valid | input | 1 | Scrambled byte valid |
| scr_sof | input | 1 | Marks the first byte of a scrambled frame |
| scr_data | input | 8 | Scrambled byte |
| err_inject | input | 1 | Continuous parity error injection |
| tx_out_valid | output | 1 | Output byte valid |
| tx_out_sof | output | 1 | Output start of frame |
| tx_out_data | output | 8 | Pre-scrambler byte with B1 written |

## Verification
The bench builds the block with FRAME_COLS=6, FRAME_ROWS=3, B1_ROW=1 and B1_COL=0. That gives an 18-byte frame with B1 at index 6, so many complete frames fit in a short run. This short frame lets the bench reach the zero code of the first frame, the one-frame delay of the code across several frames, and injection switched on and off between frames. It also reaches a frame cut short after its B1 byte by an early start-of-frame, and idle cycles placed inside a frame on both streams.

// File: rtl/bip8_pkg.sv
package bip8_pkg;

    typedef logic [7:0] byte_t;

    // Selection made for one output byte
    typedef enum logic [1:0] {
        OSEL_PASS = 2'd0,
        OSEL_ZERO = 2'd1,
        OSEL_CODE = 2'd2
    } osel_e;

    // One byte beat on either stream
    typedef struct packed {
        logic  valid;
        logic  sof;
        byte_t data;
    } beat_t;

    // Fold one byte into a running even bit-interleaved parity
    function automatic byte_t parity_fold(input byte_t acc, input byte_t b);
        return acc ^ b;
    endfunction

    // Apply diagnostic inversion to an inserted code
    function automatic byte_t apply_inject(input byte_t code, input logic inj);
        return code ^ {8{inj}};
    endfunction

endpackage

// File: rtl/bip8_frame_pos.sv
module bip8_frame_pos #(
    parameter int FRAME_LEN = 2430,
    parameter int POS_W     = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  logic             sof,
    output logic [POS_W-1:0] pos_cur,
    output logic             is_first,
    output logic             is_last
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);

    logic [POS_W-1:0] next_q;

    // Index of the byte presented in this cycle
    always_comb begin
        pos_cur  = sof ? '0 : next_q;
        is_first = (pos_cur == '0);
        is_last  = (pos_cur == LAST_POS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            next_q <= '0;
        end else if (valid) begin
            next_q <= is_last ? '0 : pos_cur + 1'b1;
        end
    end
endmodule

// File: rtl/bip8_parity_acc.sv
module bip8_parity_acc
    import bip8_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  beat_t beat,
    input  logic  first,
    input  logic  last,
    output byte_t acc_q,
    output byte_t code_q,
    output logic  have_code
);
    byte_t acc_next;

    always_comb begin
        acc_next = first ? beat.data : parity_fold(acc_q, beat.data);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q     <= '0;
            code_q    <= '0;
            have_code <= 1'b0;
        end else if (beat.valid) begin
            acc_q <= acc_next;
            if (last) begin
                code_q    <= acc_next;
                have_code <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/bip8_b1_mux.sv
module bip8_b1_mux
    import bip8_pkg::*;
(
    input  byte_t in_data,
    input  logic  at_b1,
    input  logic  have_code,
    input  byte_t code,
    input  logic  inject,
    output byte_t out_data
);
    osel_e sel;
    byte_t base;

    always_comb begin
        if (!at_b1)         sel = OSEL_PASS;
        else if (have_code) sel = OSEL_CODE;
        else                sel = OSEL_ZERO;

        unique case (sel)
            OSEL_CODE: base = code;
            OSEL_ZERO: base = '0;
            default:   base = in_data;
        endcase

        out_data = (sel == OSEL_PASS) ? base : apply_inject(base, inject);
    end
endmodule

// File: rtl/bip8_section_gen.sv
module bip8_section_gen
    import bip8_pkg::*;
#(
    parameter int FRAME_COLS = 270,
    parameter int FRAME_ROWS = 9,
    parameter int B1_ROW     = 1,
    parameter int B1_COL     = 0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tx_in_valid,
    input  logic       tx_in_sof,
    input  logic [7:0] tx_in_data,
    input  logic       scr_valid,
    input  logic       scr_sof,
    input  logic [7:0] scr_data,
    input  logic       err_inject,
    output logic       tx_out_valid,
    output logic       tx_out_sof,
    output logic [7:0] tx_out_data
);
    localparam int               FRAME_LEN = FRAME_COLS * FRAME_ROWS;
    localparam int               POS_W     = $clog2(FRAME_LEN);
    localparam logic [POS_W-1:0] B1_POS    = POS_W'(B1_ROW * FRAME_COLS + B1_COL);

    beat_t pre_beat, scr_beat;

    always_comb begin
        pre_beat = '{valid: tx_in_valid, sof: tx_in_sof, data: tx_in_data};
        scr_beat = '{valid: scr_valid,   sof: scr_sof,   data: scr_data};
    end

    // Position tracking, one counter per stream
    logic [POS_W-1:0] pre_pos, scr_pos;
    logic             pre_first, pre_last, scr_first, scr_last;

    bip8_frame_pos #(.FRAME_LEN(FRAME_LEN), .POS_W(POS_W)) u_pre_pos (
        .clk     (clk),
        .rst     (rst),
        .valid   (pre_beat.valid),
        .sof     (pre_beat.sof),
        .pos_cur (pre_pos),
        .is_first(pre_first),
        .is_last (pre_last)
    );

    bip8_frame_pos #(.FRAME_LEN(FRAME_LEN), .POS_W(POS_W)) u_scr_pos (
        .clk     (clk),
        .rst     (rst),
        .valid   (scr_beat.valid),
        .sof     (scr_beat.sof),
        .pos_cur (scr_pos),
        .is_first(scr_first),
        .is_last (scr_last)
    );

    // Parity over the scrambled stream
    byte_t acc_q, code_q;
    logic  have_code;

    bip8_parity_acc u_acc (
        .clk      (clk),
        .rst      (rst),
        .beat     (scr_beat),
        .first    (scr_first),
        .last     (scr_last),
        .acc_q    (acc_q),
        .code_q   (code_q),
        .have_code(have_code)
    );

    // B1 substitution on the pre-scrambler stream
    logic  pre_at_b1;
    byte_t mux_data;

    always_comb begin
        pre_at_b1 = (pre_pos == B1_POS);
    end

    bip8_b1_mux u_mux (
        .in_data  (pre_beat.data),
        .at_b1    (pre_at_b1),
        .have_code(have_code),
        .code     (code_q),
        .inject   (err_inject),
        .out_data (mux_data)
    );

    // Output register
    beat_t out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.valid <= pre_beat.valid;
            out_q.sof   <= pre_beat.valid & pre_beat.sof;
            if (pre_beat.valid) out_q.data <= mux_data;
        end
    end

    always_comb begin
        tx_out_valid = out_q.valid;
        tx_out_sof   = out_q.sof;
        tx_out_data  = out_q.data;
    end

    // Unused position outputs of the pre stream
    logic unused_pre;
    always_comb unused_pre = pre_first ^ pre_last;

endmodule

// File: rtl/bip8_section_chk.sv
module bip8_section_chk (
    input logic       clk,
    input logic       rst,
    input logic       tx_in_valid,
    input logic       tx_in_sof,
    input logic [7:0] tx_in_data,
    input logic       scr_valid,
    input logic       err_inject,
    input logic       tx_out_valid,
    input logic       tx_out_sof,
    input logic [7:0] tx_out_data,
    input logic       pre_at_b1,
    input logic       have_code,
    input logic [7:0] code_q,
    input logic [7:0] acc_q
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!tx_out_valid && !tx_out_sof && tx_out_data == 8'h00)); // R1

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (tx_in_valid && !pre_at_b1) |=> (tx_out_data == $past(tx_in_data))); // R2

    AST_B1_CODE: assert property (@(posedge clk) disable iff (rst)
        (tx_in_valid && pre_at_b1 && have_code && !err_inject) |=> (tx_out_data == $past(code_q))); // R5

    AST_B1_ZERO: assert property (@(posedge clk) disable iff (rst)
        (tx_in_valid && pre_at_b1 && !have_code && !err_inject) |=> (tx_out_data == 8'h00)); // R6

    AST_B1_INJECT: assert property (@(posedge clk) disable iff (rst)
        (tx_in_valid && pre_at_b1 && have_code && err_inject) |=> (tx_out_data == ~$past(code_q))); // R7

    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
        tx_in_valid |=> tx_out_valid); // R9

    AST_IDLE_OUT: assert property (@(posedge clk) disable iff (rst)
        !tx_in_valid |=> (!tx_out_valid && !tx_out_sof)); // R9

    AST_SOF_DELAY: assert property (@(posedge clk) disable iff (rst)
        (tx_in_valid && tx_in_sof) |=> tx_out_sof); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !scr_valid |=> ($stable(acc_q) && $stable(code_q) && $stable(have_code))); // R10
endmodule

bind bip8_section_gen bip8_section_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .tx_in_valid (tx_in_valid),
    .tx_in_sof   (tx_in_sof),
    .tx_in_data  (tx_in_data),
    .scr_valid   (scr_valid),
    .err_inject  (err_inject),
    .tx_out_valid(tx_out_valid),
    .tx_out_sof  (tx_out_sof),
    .tx_out_data (tx_out_data),
    .pre_at_b1   (pre_at_b1),
    .have_code   (have_code),
    .code_q      (code_q),
    .acc_q       (acc_q)
);

// File: tb/sim_bip8_section_gen.sv
module sim_bip8_section_gen;
    localparam int COLS = 6;
    localparam int ROWS = 3;
    localparam int FLEN = COLS * ROWS;
    localparam int B1IX = 1 * COLS + 0;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_in_valid = 1'b0, tx_in_sof = 1'b0;
    logic [7:0] tx_in_data = 8'h00;
    logic       scr_valid = 1'b0, scr_sof = 1'b0;
    logic [7:0] scr_data = 8'h00;
    logic       err_inject = 1'b0;
    logic       tx_out_valid, tx_out_sof;
    logic [7:0] tx_out_data;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    // Bench model of the code register
    logic [7:0] m_code = 8'h00;
    bit         m_have = 1'b0;

    always #2.5 clk = ~clk;

    bip8_section_gen #(.FRAME_COLS(COLS), .FRAME_ROWS(ROWS), .B1_ROW(1), .B1_COL(0)) u0 (
        .clk(clk), .rst(rst),
        .tx_in_valid(tx_in_valid), .tx_in_sof(tx_in_sof), .tx_in_data(tx_in_data),
        .scr_valid(scr_valid), .scr_sof(scr_sof), .scr_data(scr_data),
        .err_inject(err_inject),
        .tx_out_valid(tx_out_valid), .tx_out_sof(tx_out_sof), .tx_out_data(tx_out_data)
    );

    function automatic logic [7:0] pre_byte(input int seed, input int i);
        return 8'((seed * 37 + i * 11 + 5) & 255);
    endfunction

    function automatic logic [7:0] scr_byte(input int seed, input int i);
        return 8'(((seed * 53) ^ (i * 29 + 3)) & 255);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One cycle on both streams, then sample after the edge
    task automatic beat(input bit pv, input bit ps, input logic [7:0] pd,
                        input bit sv, input bit ss, input logic [7:0] sd,
                        input string req, input logic [7:0] exp_d);
        @(negedge clk);
        tx_in_valid = pv; tx_in_sof = ps; tx_in_data = pd;
        scr_valid = sv;   scr_sof = ss;   scr_data = sd;
        @(posedge clk);
        #1;
        check({req, " valid"}, {31'd0, tx_out_valid}, {31'd0, pv});
        check({req, " sof"}, {31'd0, tx_out_sof}, {31'd0, pv & ps});
        if (pv) check({req, " data"}, {24'd0, tx_out_data}, {24'd0, exp_d});
    endtask

    // Full frame on both streams; idle cycle inserted before index gap_at (<0: none)
    task automatic run_frame(input int seed, input bit inj, input int gap_at, input string req);
        logic [7:0] acc = 8'h00;
        err_inject = inj;
        for (int i = 0; i < FLEN; i++) begin
            logic [7:0] exp_d;
            if (i == gap_at)
                beat(1'b0, 1'b1, 8'hA5, 1'b0, 1'b1, 8'h5A, "R10 idle", 8'h00);
            exp_d = pre_byte(seed, i);
            if (i == B1IX) exp_d = (m_have ? m_code : 8'h00) ^ {8{inj}};
            beat(1'b1, i == 0, pre_byte(seed, i), 1'b1, i == 0, scr_byte(seed, i),
                 (i == B1IX) ? req : "R2", exp_d);
            acc ^= scr_byte(seed, i);
        end
        m_code = acc;
        m_have = 1'b1;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R1 valid", {31'd0, tx_out_valid}, 32'd0);
        check("R1 sof", {31'd0, tx_out_sof}, 32'd0);
        check("R1 data", {24'd0, tx_out_data}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_first_zero;
        run_frame(1, 1'b0, -1, "R6 R3");
    endtask

    task automatic t_chain;
        run_frame(2, 1'b0, -1, "R4 R5");
        run_frame(3, 1'b0, -1, "R4 R5");
        run_frame(4, 1'b0, -1, "R5");
    endtask

    task automatic t_inject;
        run_frame(5, 1'b1, -1, "R7");
        run_frame(6, 1'b1, -1, "R7");
        run_frame(7, 1'b0, -1, "R7 off");
    endtask

    task automatic t_gaps;
        run_frame(8, 1'b0, 3, "R10");
        run_frame(9, 1'b0, 12, "R10");
        run_frame(10, 1'b0, -1, "R10 R4");
    endtask

    // Frame cut short after its B1 byte, then restarted by sof
    task automatic t_restart;
        err_inject = 1'b0;
        for (int i = 0; i < 10; i++) begin
            logic [7:0] exp_d;
            exp_d = (i == B1IX) ? m_code : pre_byte(20, i);
            beat(1'b1, i == 0, pre_byte(20, i), 1'b1, i == 0, scr_byte(20, i),
                 (i == B1IX) ? "R8 R3" : "R8", exp_d);
        end
        run_frame(21, 1'b0, -1, "R8 R5");
        run_frame(22, 1'b0, -1, "R8 R5");
    endtask

    task automatic t_inject_first;
        t_reset();
        m_have = 1'b0;
        m_code = 8'h00;
        run_frame(30, 1'b1, -1, "R7 R6");
        run_frame(31, 1'b0, -1, "R5");
    endtask

    initial begin
        t_reset();
        t_first_zero();
        t_chain();
        t_inject();
        t_gaps();
        t_restart();
        t_inject_first();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule